// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command sequencer placed in front of a two-bank NOR-style flash array. Software drives it over a simple 16-bit memory bus: writes carry either command codes or program data, and reads return array contents, a status byte or the sector protection bitmap, depending on the current read mode. Multi-cycle operations are started by a two-write protocol: a setup code followed by a confirm or data write aimed at an address inside the target sector.

The array itself is a small behavioural memory. The lower bank holds large sectors and the upper bank holds small ones. A busy counter stands in for program and erase time. While it runs, the ready bit of the status byte reads 0 and the controller ignores every command except the one that selects status reads. Each sector has a protection bit, and that bit blocks erase and program of the sector. The bitmap is set and cleared through its own two-write sequence.

Default geometry: the lower bank has 4 sectors of 16 halfwords at byte addresses 0x00-0x7F. The upper bank has 4 sectors of 8 halfwords at 0x80-0xBF. Byte addresses 0xC0-0xFF are unmapped.

Top module: `flashcmd_ctrl`

## Requirements
- R1: After reset every array halfword reads 0xFFFF, reads are in array mode, the status byte is 0x80 and the protection bitmap is 0x0000.
- R2: A read strobe returns `bus_rdata` with `bus_rvalid` high on the following cycle. The returned value depends on the read mode:
  - array mode returns the halfword at byte address >> 1, or 0x0000 for an unmapped address;
  - status mode returns {8'h00, status} at any address;
  - protection mode returns the bitmap at byte address 0x90 (upper-bank base + 0x10) and 0x0000 at any other address.
- R3: When idle, command writes act as follows:
  - 0x70 selects status mode;
  - 0x90 selects protection mode;
  - 0xFF selects array mode;
  - 0x50 clears status bits 1, 4 and 5 and leaves bit 7 unchanged.
- R4: Writing 0x20 and then 0xD0 to an address in an unprotected sector holds status bit 7 at 0 for ERASE_CYCLES cycles. After that the whole sector reads 0xFFFF and other sectors are unchanged.
- R5: Writing 0x40 and then a data write holds status bit 7 at 0 for PROG_CYCLES cycles. After that the destination halfword holds the old value ANDed with the data.
- R6: Writing 0x60 and then 0x01 sets the protection bit of the addressed sector, and 0x60 then 0xD0 clears it. Lower-bank sector n maps to bitmap bit n, and upper-bank sector n maps to bit 8+n.
- R7: An erase or program aimed at a protected or unmapped sector leaves the array unchanged. It sets status bit 1 together with bit 5 (erase) or bit 4 (program), and bit 7 stays 1.
- R8: While busy, all writes are ignored except 0x70, which still selects status mode. The protection bitmap does not change while busy.
- R9: After 0x20 or 0x60, a second write that is not a valid confirm sets status bits 4 and 5, leaves status mode selected and returns the controller to idle.
- R10: Accepting 0x20, 0x40 or 0x60 as a first write selects status mode.
- R11: When idle, any other write value is ignored and the read mode stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe (command or data) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data / command code |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
Read data is due exactly one cycle after the read strobe. A command's effect on the read mode or the status flags appears on the first read strobed after the edge that accepts the command. Array changes and the return of the ready bit become visible exactly ERASE_CYCLES or PROG_CYCLES edges after the confirm or data write. The bench drives inputs just after the falling edge and advances a behavioural model on each rising edge. It compares `bus_rvalid` and `bus_rdata` against that model on every falling edge, so every busy-window status poll is checked at its exact cycle.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  localparam int LOC_W = 4;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_PROT} rd_mode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ERASE, SQ_PROT, SQ_PROG} sq_state_e;

  typedef struct packed {
    logic             ok;
    logic [LOC_W-1:0] bit_idx;
  } sect_loc_t;

  localparam logic [15:0] C_ERASE   = 16'h0020;
  localparam logic [15:0] C_CONFIRM = 16'h00D0;
  localparam logic [15:0] C_PROG    = 16'h0040;
  localparam logic [15:0] C_STATUS  = 16'h0070;
  localparam logic [15:0] C_CLEAR   = 16'h0050;
  localparam logic [15:0] C_ARRAY   = 16'h00FF;
  localparam logic [15:0] C_PSETUP  = 16'h0060;
  localparam logic [15:0] C_PSET    = 16'h0001;
  localparam logic [15:0] C_RDPROT  = 16'h0090;

  // Map a byte address to its sector's protection bit position.
  function automatic sect_loc_t locate(input int unsigned addr, input int unsigned b1_base,
                                       input int unsigned b0_bytes, input int unsigned b1_bytes,
                                       input int unsigned n0, input int unsigned n1,
                                       input int unsigned b1_bit0);
    sect_loc_t   r;
    int unsigned s;
    r = '0;
    if (addr < b1_base) begin
      s = addr / b0_bytes;
      r.ok = (s < n0);
      r.bit_idx = LOC_W'(s);
    end else begin
      s = (addr - b1_base) / b1_bytes;
      r.ok = (s < n1);
      r.bit_idx = LOC_W'(b1_bit0 + s);
    end
    return r;
  endfunction
endpackage

// File: rtl/fcmd_prot.sv
module fcmd_prot
  import flashcmd_pkg::*;
#(
  parameter int PROT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [LOC_W-1:0]  bit_i,
  input  logic              busy_i,
  output logic [PROT_W-1:0] map_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) map_o <= '0;
    else if (set_i) map_o[bit_i] <= 1'b1;
    else if (clr_i) map_o[bit_i] <= 1'b0;
  end

  p_busy_holds_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(map_o));
endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int MEM_HW  = 96,
  parameter int B1_BASE = 128,
  parameter int B0_BYTES = 32,
  parameter int B1_BYTES = 16,
  parameter int N0 = 4,
  parameter int N1 = 4,
  parameter int B1_BIT0 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_do_i,
  input  logic              prog_do_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [15:0]       op_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_word_o
);
  localparam int IDX_W = $clog2(MEM_HW);

  logic [15:0]       mem [MEM_HW];
  logic [ADDR_W-1:0] op_full, rd_full;
  logic [IDX_W-1:0]  op_idx, rd_idx;
  logic              op_in, rd_in;
  sect_loc_t         eloc;

  assign op_full = op_addr_i >> 1;
  assign rd_full = rd_addr_i >> 1;
  assign op_in   = (int'(op_full) < MEM_HW);
  assign rd_in   = (int'(rd_full) < MEM_HW);
  assign op_idx  = IDX_W'(op_full);
  assign rd_idx  = IDX_W'(rd_full);
  assign eloc    = locate(int'(op_addr_i), B1_BASE, B0_BYTES, B1_BYTES, N0, N1, B1_BIT0);
  assign rd_word_o = rd_in ? mem[rd_idx] : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_HW; i++) mem[i] <= 16'hFFFF;
    end else if (erase_do_i) begin
      for (int i = 0; i < MEM_HW; i++)
        if (locate(i * 2, B1_BASE, B0_BYTES, B1_BYTES, N0, N1, B1_BIT0) == eloc)
          mem[i] <= 16'hFFFF;
    end else if (prog_do_i && op_in) begin
      mem[op_idx] <= mem[op_idx] & op_data_i;
    end
  end

  p_erase_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_do_i |=> mem[$past(op_idx)] == 16'hFFFF);
  p_prog_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_do_i && op_in) |=> mem[$past(op_idx)] == ($past(mem[op_idx]) & $past(op_data_i)));
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PROT_W  = 16,
  parameter int B1_BASE = 128,
  parameter int B0_BYTES = 32,
  parameter int B1_BYTES = 16,
  parameter int N0 = 4,
  parameter int N1 = 4,
  parameter int B1_BIT0 = 8,
  parameter int ERASE_CYCLES = 24,
  parameter int PROG_CYCLES  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [PROT_W-1:0] prot_map_i,
  output logic              busy_o,
  output logic [7:0]        status_o,
  output rd_mode_e          rmode_o,
  output logic              erase_do_o,
  output logic              prog_do_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [15:0]       op_data_o,
  output logic              pset_o,
  output logic              pclr_o,
  output logic [LOC_W-1:0]  pbit_o
);
  localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  sq_state_e       state_q;
  logic            busy_q, op_erase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]      err_q;  // {erase, program, protected}
  sect_loc_t       loc;
  logic            cmd_ok, hit, is_op, done, abort, refuse, start;

  assign loc    = locate(int'(addr_i), B1_BASE, B0_BYTES, B1_BYTES, N0, N1, B1_BIT0);
  assign hit    = !loc.ok || prot_map_i[loc.bit_idx];
  assign cmd_ok = wr_i && !busy_q;
  assign is_op  = (state_q == SQ_ERASE && wdata_i == C_CONFIRM) || (state_q == SQ_PROG);
  assign refuse = cmd_ok && is_op && hit;
  assign start  = cmd_ok && is_op && !hit;
  assign abort  = cmd_ok && ((state_q == SQ_ERASE && wdata_i != C_CONFIRM) ||
                  (state_q == SQ_PROT && wdata_i != C_PSET && wdata_i != C_CONFIRM));
  assign done   = busy_q && (cnt_q == '0);
  assign pset_o = cmd_ok && state_q == SQ_PROT && wdata_i == C_PSET && loc.ok;
  assign pclr_o = cmd_ok && state_q == SQ_PROT && wdata_i == C_CONFIRM && loc.ok;
  assign pbit_o = loc.bit_idx;
  assign erase_do_o = done && op_erase_q;
  assign prog_do_o  = done && !op_erase_q;
  assign busy_o   = busy_q;
  assign status_o = {~busy_q, 1'b0, err_q[2], err_q[1], 2'b00, err_q[0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE; busy_q <= 1'b0; cnt_q <= '0; err_q <= '0;
      rmode_o <= RD_ARRAY; op_erase_q <= 1'b0; op_addr_o <= '0; op_data_o <= '0;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
      if (wr_i && wdata_i == C_STATUS) rmode_o <= RD_STATUS;
    end else if (wr_i) begin
      unique case (state_q)
        SQ_IDLE: begin
          case (wdata_i)
            C_ERASE:  begin state_q <= SQ_ERASE; rmode_o <= RD_STATUS; end
            C_PSETUP: begin state_q <= SQ_PROT;  rmode_o <= RD_STATUS; end
            C_PROG:   begin state_q <= SQ_PROG;  rmode_o <= RD_STATUS; end
            C_STATUS: rmode_o <= RD_STATUS;
            C_RDPROT: rmode_o <= RD_PROT;
            C_ARRAY:  rmode_o <= RD_ARRAY;
            C_CLEAR:  err_q <= '0;
            default:  ;
          endcase
        end
        SQ_ERASE, SQ_PROG: begin
          state_q <= SQ_IDLE;
          if (abort) err_q <= err_q | 3'b110;
          else if (refuse) err_q <= err_q | ((state_q == SQ_ERASE) ? 3'b101 : 3'b011);
          else begin
            busy_q     <= 1'b1;
            op_erase_q <= (state_q == SQ_ERASE);
            cnt_q      <= (state_q == SQ_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
            op_addr_o  <= addr_i;
            op_data_o  <= wdata_i;
          end
        end
        SQ_PROT: begin
          state_q <= SQ_IDLE;
          if (abort) err_q <= err_q | 3'b110;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  p_refuse_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (status_o[7] && status_o[1]));
  p_busy_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> (rmode_o == $past(rmode_o) || rmode_o == RD_STATUS));
  p_abort_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (status_o[5:4] == 2'b11 && rmode_o == RD_STATUS && state_q == SQ_IDLE));
  p_clear_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && state_q == SQ_IDLE && wdata_i == C_CLEAR) |=> (status_o[5:4] == 2'b00 && !status_o[1]));
endmodule

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int B0_SECTORS   = 4,
  parameter int B0_SECT_HW   = 16,
  parameter int B1_SECTORS   = 4,
  parameter int B1_SECT_HW   = 8,
  parameter int B1_BIT0      = 8,
  parameter int ERASE_CYCLES = 24,
  parameter int PROG_CYCLES  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int PROT_W   = 2 ** LOC_W;
  localparam int B0_BYTES = B0_SECT_HW * 2;
  localparam int B1_BYTES = B1_SECT_HW * 2;
  localparam int B1_BASE  = B0_SECTORS * B0_BYTES;
  localparam int MEM_HW   = B0_SECTORS * B0_SECT_HW + B1_SECTORS * B1_SECT_HW;
  localparam logic [ADDR_W-1:0] PROT_RD_ADDR = ADDR_W'(B1_BASE + 16);

  logic              busy, erase_do, prog_do, pset, pclr;
  logic [7:0]        status;
  rd_mode_e          rmode;
  logic [ADDR_W-1:0] op_addr;
  logic [15:0]       op_data, arr_word;
  logic [LOC_W-1:0]  pbit;
  logic [PROT_W-1:0] prot_map;

  fcmd_seq #(.ADDR_W(ADDR_W), .PROT_W(PROT_W), .B1_BASE(B1_BASE), .B0_BYTES(B0_BYTES),
    .B1_BYTES(B1_BYTES), .N0(B0_SECTORS), .N1(B1_SECTORS), .B1_BIT0(B1_BIT0),
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .prot_map_i(prot_map), .busy_o(busy), .status_o(status), .rmode_o(rmode),
    .erase_do_o(erase_do), .prog_do_o(prog_do), .op_addr_o(op_addr), .op_data_o(op_data),
    .pset_o(pset), .pclr_o(pclr), .pbit_o(pbit));

  fcmd_prot #(.PROT_W(PROT_W)) u_prot (
    .clk(clk), .rst_n(rst_n), .set_i(pset), .clr_i(pclr), .bit_i(pbit),
    .busy_i(busy), .map_o(prot_map));

  fcmd_array #(.ADDR_W(ADDR_W), .MEM_HW(MEM_HW), .B1_BASE(B1_BASE), .B0_BYTES(B0_BYTES),
    .B1_BYTES(B1_BYTES), .N0(B0_SECTORS), .N1(B1_SECTORS), .B1_BIT0(B1_BIT0)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_do_i(erase_do), .prog_do_i(prog_do),
    .op_addr_i(op_addr), .op_data_i(op_data), .rd_addr_i(bus_addr), .rd_word_o(arr_word));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        unique case (rmode)
          RD_STATUS: bus_rdata <= {8'h00, status};
          RD_PROT:   bus_rdata <= (bus_addr == PROT_RD_ADDR) ? prot_map : 16'h0000;
          default:   bus_rdata <= arr_word;
        endcase
      end
    end
  end

  p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && busy && rmode == RD_STATUS) |=> (bus_rvalid && !bus_rdata[7]));
endmodule

// File: tb/flashcmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flashcmd_ctrl_tb_top;
  localparam int ER_N = 24;
  localparam int PG_N = 6;
  localparam int NHW  = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] rdata;
  logic rvalid;

  always #2.5 clk = ~clk;

  flashcmd_ctrl dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(wr_i), .bus_rd(rd_i), .bus_addr(addr_i),
    .bus_wdata(data_i), .bus_rdata(rdata), .bus_rvalid(rvalid));

  // ---- behavioural reference model ----
  int m_mem [NHW];
  int m_mode;      // 0 array, 1 status, 2 protection
  int m_pend;      // pending first-cycle code, 0 = none
  int m_left;      // busy cycles left
  int m_err;       // status error bits as they appear in the byte
  int m_prot;
  int m_op_addr, m_op_data, m_op_erase;
  int exp_v, exp_d;
  int vectors = 0, errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  function automatic int skey(int a);
    if (a < 128) return (a / 32 < 4) ? a / 32 : -1;
    if ((a - 128) / 16 < 4) return 8 + (a - 128) / 16;
    return -1;
  endfunction

  function automatic int m_read(int a);
    if (m_mode == 1) return (m_left > 0 ? 0 : 'h80) | m_err;
    if (m_mode == 2) return (a == 'h90) ? m_prot : 0;
    return ((a >> 1) < NHW) ? m_mem[a >> 1] : 0;
  endfunction

  task automatic m_write(int a, int d);
    int k;
    k = skey(a);
    if (m_pend == 0) begin
      case (d)
        'h20, 'h40, 'h60: begin m_pend = d; m_mode = 1; end
        'h70: m_mode = 1;
        'h90: m_mode = 2;
        'hFF: m_mode = 0;
        'h50: m_err = 0;
        default: ;
      endcase
    end else begin
      if (m_pend == 'h60) begin
        if (d == 'h01 && k >= 0) m_prot = m_prot | (1 << k);
        else if (d == 'hD0 && k >= 0) m_prot = m_prot & ~(1 << k);
        else if (d != 'h01 && d != 'hD0) m_err = m_err | 'h30;
      end else if (m_pend == 'h20 && d != 'hD0) begin
        m_err = m_err | 'h30;
      end else begin
        if (k < 0 || ((m_prot >> k) & 1) == 1)
          m_err = m_err | 'h02 | (m_pend == 'h20 ? 'h20 : 'h10);
        else begin
          m_left = (m_pend == 'h20) ? ER_N : PG_N;
          m_op_erase = (m_pend == 'h20); m_op_addr = a; m_op_data = d;
        end
      end
      m_pend = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 'hFFFF;
      m_mode = 0; m_pend = 0; m_left = 0; m_err = 0; m_prot = 0; exp_v = 0; exp_d = 0;
    end else begin
      exp_v = rd_i;
      if (rd_i) exp_d = m_read(addr_i);
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          if (m_op_erase) begin
            for (int i = 0; i < NHW; i++) if (skey(i * 2) == skey(m_op_addr)) m_mem[i] = 'hFFFF;
          end else if ((m_op_addr >> 1) < NHW)
            m_mem[m_op_addr >> 1] = m_mem[m_op_addr >> 1] & m_op_data;
        end
        if (wr_i && data_i == 16'h0070) m_mode = 1;
      end else if (wr_i) m_write(addr_i, data_i);
    end
  end

  // ---- comparison on every falling edge ----
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      if (rvalid !== exp_v[0] || (exp_v != 0 && rdata !== exp_d[15:0])) begin
        errors++;
        $display("FAIL %s: rvalid=%0b rdata=%04h expected rvalid=%0b rdata=%04h at %0t",
                 cur_req, rvalid, rdata, exp_v[0], exp_d[15:0], $time);
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1; wr_i = 1; rd_i = 0; addr_i = 8'(a); data_i = 16'(d);
  endtask
  task automatic rd(int a);
    @(negedge clk); #1; wr_i = 0; rd_i = 1; addr_i = 8'(a);
  endtask
  task automatic nop(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; wr_i = 0; rd_i = 0; end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    // R1: reset state
    cur_req = "R1"; rd('h00); rd('hBE); wr('h70, 0); rd('h10);
    wr('h00, 'h90); rd('h90); wr('h00, 'hFF);
    // R2: unmapped array read, protection read off the bitmap address
    cur_req = "R2"; rd('hC4); wr('h00, 'h90); rd('h92); wr('h00, 'hFF); nop(1);
    // R5 / R10: program with polling through the busy window
    cur_req = "R5"; wr('h20, 'h40); rd('h20); wr('h22, 'h1234);
    for (int i = 0; i < PG_N + 2; i++) rd('h22);
    wr('h00, 'hFF); rd('h22); rd('h20);
    wr('h20, 'h40); wr('h22, 'hFF0F); nop(PG_N); wr('h00, 'hFF); rd('h22);
    wr('h00, 'h40); wr('h02, 'h00AA); nop(PG_N); wr('h00, 'hFF); rd('h02);
    wr('h80, 'h40); wr('h84, 'h5555); nop(PG_N); wr('h00, 'hFF); rd('h84);
    // R4 / R8: erase lower-bank sector 1, commands during busy ignored
    cur_req = "R4"; wr('h30, 'h20); wr('h30, 'hD0); rd('h30);
    cur_req = "R8"; wr('h40, 'h60); wr('h40, 'h01); wr('h00, 'hFF); rd('h00);
    wr('h00, 'h90); rd('h90); wr('h00, 'h70);
    for (int i = 0; i < ER_N; i++) rd('h30);
    cur_req = "R4"; wr('h00, 'hFF); rd('h22); rd('h3E); rd('h02); rd('h84);
    wr('h00, 'h90); rd('h90);
    // R6: protection set / clear and the bitmap layout
    cur_req = "R6"; wr('h90, 'h60); wr('h90, 'h01); wr('h44, 'h60); wr('h44, 'h01);
    wr('h00, 'h90); rd('h90); wr('h40, 'h60); wr('h40, 'hD0); wr('h00, 'h90); rd('h90);
    // R7: refused operations
    cur_req = "R7"; wr('h92, 'h40); wr('h92, 'h0000); rd('h00); nop(PG_N);
    wr('h00, 'hFF); rd('h92);
    cur_req = "R3"; wr('h00, 'h50); wr('h00, 'h70); rd('h00);
    cur_req = "R7"; wr('h98, 'h20); wr('h98, 'hD0); rd('h98); nop(ER_N);
    wr('h00, 'hFF); rd('h84); wr('h00, 'h50);
    wr('hC2, 'h40); wr('hC2, 'h0000); rd('hC2); wr('h00, 'h50);
    // R9: aborted sequences
    cur_req = "R9"; wr('h00, 'hFF); wr('h10, 'h20); wr('h10, 'h33); rd('h10); rd('h12);
    wr('h00, 'h50); wr('h00, 'hFF); wr('h10, 'h60); wr('h10, 'h77); rd('h10);
    wr('h00, 'h90); rd('h90);
    // R11 / R3: stray idle writes ignored, mode switches
    cur_req = "R11"; wr('h00, 'h50); wr('h00, 'hFF); wr('h00, 'h0012); rd('h22);
    wr('h00, 'h70); wr('h00, 'h00D0); rd('h22);
    cur_req = "R3"; wr('h00, 'hFF); rd('h02); wr('h00, 'h90); rd('h90); nop(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule